// File: doc/BRIEF.md
# Single-Wire Slave Frame Engine

This block parses the frames that a bus master sends to one slave on a pulse-width coded single-wire bus. A symbol layer below it has already turned bus pulses into symbols: a zero bit, a one bit, a frame start, or a bus reset. The engine takes these symbols one at a time. It matches the device number against the address set by two strap pins, decodes the register number and the transfer direction, and moves 8 or 16 data bits between the bus and a small register file. It checks or produces an even parity bit, and it sends or receives the acknowledge bit.

On slots the slave owns, such as read data, read parity and the write acknowledge, the engine tells the symbol layer which value to put on the bus (`tx_en`, `tx_one`). It then reads the bus value back through the same symbol stream. A completed frame ends in exactly one one-cycle event: a read strobe, a write strobe, or an acknowledge-error event. The register file holds the control, sensor-control and rate registers, a set of constant identification registers, and two registers supplied from outside: a status byte and a temperature word.

The state machine has these states: IDLE (waiting for a start), DEVNUM (3 device bits), REGNUM (6 register bits), DIR (direction bit), DATA (8 or 16 bits), PARITY, ACK and DRAIN (ignore bits until the next start). The transitions are:
- A start symbol moves any state to DEVNUM.
- A bus reset moves any state to IDLE.
- DEVNUM moves to REGNUM when the address matches or is broadcast, and to DRAIN otherwise.
- REGNUM moves to DIR.
- DIR moves to DATA, except that a broadcast read moves it to DRAIN.
- DATA moves to PARITY after the last data bit.
- PARITY moves to ACK.
- ACK moves to DRAIN.

Top module: `sp_slave_engine`

## Requirements
- R1: The slave address is the 2-bit strap value plus one (straps 00..11 give 1..4). A frame whose 3-bit device number is neither that address nor 0 produces no bus drive (`tx_en` stays 0) and no strobe. Register 0x00 reads back the address.
- R2: Registers 0x00, 0x04 and 0x20 transfer 8 data bits. Every other register number transfers 16 bits. Bits go MSB first.
- R3: On a read, the engine drives each data bit and then a parity bit. The parity bit makes the total number of ones even over the device number, the register number, the direction bit (1 = read, 0 = write), the data and the parity bit itself.
- R4: On a write, the engine drives the acknowledge slot to 1 when that same parity sum is even and to 0 otherwise.
- R5: A write takes effect only when the acknowledge slot reads back 1. In that case `wr_stb` pulses once with the register number and data. The writable bits are control 0x05 (mask 0x0017), sensor control 0x0A (mask 0x0003) and rate 0x20 (mask 0x03).
- R6: An acknowledge of 0, on a read or a write, pulses `ack_err` and produces no read or write strobe.
- R7: `rd_stb` pulses only after the master returns an acknowledge of 1 on a read.
- R8: Device number 0 is broadcast. Broadcast reads are ignored. A broadcast write changes only bits 1:0 of register 0x05 and leaves every other register unchanged.
- R9: A start received mid-frame abandons that frame without an error and begins a new one. A bus reset symbol abandons the frame and waits for a start.
- R10: Bits received after the acknowledge slot are ignored until the next start.
- R11: Reset values are: 0x01 = 0x104C, 0x02 = 0x008D, 0x03 = 0x0001, 0x08 = 0x014A, 0x20 = 0x02, and 0x05 = 0x0A = 0. Register 0x04 returns the status input and 0x09 returns the temperature input. Undefined register numbers read as 0 with normal parity and acknowledge.
- R12: Writing 1 to bit 0 of register 0x05 sets that bit for exactly one cycle. The writable registers then return to their reset values.
- R13: The straps are sampled again at every start symbol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_valid | input | 1 | A decoded symbol is present this cycle |
| sym_code | input | 2 | Symbol: 0 zero bit, 1 one bit, 2 start, 3 bus reset |
| strap | input | 2 | Address strap pins |
| status_in | input | 8 | Value returned for register 0x04 |
| temp_in | input | 16 | Value returned for register 0x09 |
| tx_en | output | 1 | The next bit slot belongs to the slave |
| tx_one | output | 1 | Value the slave places in that slot |
| rd_stb | output | 1 | One-cycle pulse: read acknowledged |
| wr_stb | output | 1 | One-cycle pulse: write committed |
| reg_addr | output | 6 | Register number of the current or last frame |
| wr_data | output | 16 | Write data accompanying `wr_stb` |
| ack_err | output | 1 | One-cycle pulse: acknowledge was 0 |
| ctrl_reg | output | 16 | Device control register 0x05 |
| tctl_reg | output | 16 | Sensor control register 0x0A |
| rate_reg | output | 8 | Rate register 0x20 |

## Verification
In the cycle after the acknowledge symbol, the engine decides between a strobe and an error event and also drops to DRAIN. The register file may act on a committed write in that same window. The bench provokes both outcomes: it flips the parity bit on writes and returns a master acknowledge of 0 on reads. A scoreboard queue holds the one event expected per frame and fails on any event that is extra, missing or of the wrong kind. Repeat reads then show that a refused write left the register unchanged.

// File: rtl/sp_pkg.sv
package sp_pkg;
    localparam int DATA_W  = 16;
    localparam int SHORT_W = 8;
    localparam int DEV_W   = 3;
    localparam int REG_W   = 6;
    localparam int STRAP_W = 2;
    localparam int CNT_W   = $clog2(DATA_W + 1);

    typedef enum logic [1:0] {
        SYM_B0    = 2'd0,
        SYM_B1    = 2'd1,
        SYM_START = 2'd2,
        SYM_BRST  = 2'd3
    } sym_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_DEVNUM, ST_REGNUM, ST_DIR,
        ST_DATA, ST_PARITY, ST_ACK, ST_DRAIN
    } fsm_e;

    localparam logic [REG_W-1:0] RA_DEVNUM = 6'h00;
    localparam logic [REG_W-1:0] RA_MFR    = 6'h01;
    localparam logic [REG_W-1:0] RA_PART   = 6'h02;
    localparam logic [REG_W-1:0] RA_CAPS   = 6'h03;
    localparam logic [REG_W-1:0] RA_STAT   = 6'h04;
    localparam logic [REG_W-1:0] RA_CTRL   = 6'h05;
    localparam logic [REG_W-1:0] RA_TCAPS  = 6'h08;
    localparam logic [REG_W-1:0] RA_TEMP   = 6'h09;
    localparam logic [REG_W-1:0] RA_TCTL   = 6'h0A;
    localparam logic [REG_W-1:0] RA_RATE   = 6'h20;

    localparam logic [DATA_W-1:0]  MFR_VAL    = 16'h104C;
    localparam logic [DATA_W-1:0]  PART_VAL   = 16'h008D;
    localparam logic [DATA_W-1:0]  CAPS_VAL   = 16'h0001;
    localparam logic [DATA_W-1:0]  TCAPS_VAL  = 16'h014A;
    localparam logic [SHORT_W-1:0] RATE_RST   = 8'h02;
    localparam logic [DATA_W-1:0]  CTRL_MASK  = 16'h0017;
    localparam logic [DATA_W-1:0]  TCTL_MASK  = 16'h0003;
    localparam logic [SHORT_W-1:0] RATE_MASK  = 8'h03;
    localparam logic [DATA_W-1:0]  BCAST_MASK = 16'h0003;

    function automatic logic is_short(input logic [REG_W-1:0] a);
        return (a == RA_DEVNUM) || (a == RA_STAT) || (a == RA_RATE);
    endfunction
endpackage

// File: rtl/sp_regfile.sv
module sp_regfile
    import sp_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [REG_W-1:0]    addr,
    input  logic [DEV_W-1:0]    dev_num,
    input  logic [SHORT_W-1:0]  status_in,
    input  logic [DATA_W-1:0]   temp_in,
    input  logic                wr_stb,
    input  logic                wr_bcast,
    input  logic [DATA_W-1:0]   wr_data,
    output logic [DATA_W-1:0]   rd_val,
    output logic [DATA_W-1:0]   ctrl_reg,
    output logic [DATA_W-1:0]   tctl_reg,
    output logic [SHORT_W-1:0]  rate_reg
);
    logic rst_pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_reg <= '0;
            tctl_reg <= '0;
            rate_reg <= RATE_RST;
            rst_pend <= 1'b0;
        end else if (rst_pend) begin
            ctrl_reg <= '0;
            tctl_reg <= '0;
            rate_reg <= RATE_RST;
            rst_pend <= 1'b0;
        end else if (wr_stb) begin
            if (wr_bcast) begin
                if (addr == RA_CTRL) begin
                    ctrl_reg <= (ctrl_reg & ~BCAST_MASK) | (wr_data & BCAST_MASK);
                    rst_pend <= wr_data[0];
                end
            end else begin
                case (addr)
                    RA_CTRL: begin
                        ctrl_reg <= wr_data & CTRL_MASK;
                        rst_pend <= wr_data[0];
                    end
                    RA_TCTL: tctl_reg <= wr_data & TCTL_MASK;
                    RA_RATE: rate_reg <= wr_data[SHORT_W-1:0] & RATE_MASK;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (addr)
            RA_DEVNUM: rd_val = DATA_W'(dev_num);
            RA_MFR:    rd_val = MFR_VAL;
            RA_PART:   rd_val = PART_VAL;
            RA_CAPS:   rd_val = CAPS_VAL;
            RA_STAT:   rd_val = DATA_W'(status_in);
            RA_CTRL:   rd_val = ctrl_reg;
            RA_TCAPS:  rd_val = TCAPS_VAL;
            RA_TEMP:   rd_val = temp_in;
            RA_TCTL:   rd_val = tctl_reg;
            RA_RATE:   rd_val = DATA_W'(rate_reg);
            default:   rd_val = '0;
        endcase
    end
endmodule

// File: rtl/sp_frame_fsm.sv
module sp_frame_fsm
    import sp_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sym_valid,
    input  logic [1:0]          sym_code,
    input  logic [STRAP_W-1:0]  strap,
    input  logic [DATA_W-1:0]   rd_val,
    output logic [DEV_W-1:0]    my_addr,
    output logic                tx_en,
    output logic                tx_one,
    output logic                rd_stb,
    output logic                wr_stb,
    output logic                wr_bcast,
    output logic [REG_W-1:0]    reg_addr,
    output logic [DATA_W-1:0]   wr_data,
    output logic                ack_err
);
    fsm_e               state, nxt;
    logic [CNT_W-1:0]   cnt;
    logic [DEV_W-1:0]   dev;
    logic [DATA_W-1:0]  shreg;
    logic               par;
    logic               is_rd;
    logic               len16;
    logic               is_bit;
    logic               bval;
    logic               is_start;
    logic [DEV_W-1:0]   dev_full;
    logic               data_last;
    logic               bcast;

    assign is_bit    = sym_valid && (sym_code == SYM_B0 || sym_code == SYM_B1);
    assign bval      = (sym_code == SYM_B1);
    assign is_start  = sym_valid && (sym_code == SYM_START);
    assign dev_full  = {dev[DEV_W-2:0], bval};
    assign bcast     = (dev == '0);
    assign data_last = len16 ? (cnt == CNT_W'(DATA_W - 1)) : (cnt == CNT_W'(SHORT_W - 1));

    // next-state decode
    always_comb begin
        nxt = state;
        if (is_start) begin
            nxt = ST_DEVNUM;
        end else if (sym_valid && sym_code == SYM_BRST) begin
            nxt = ST_IDLE;
        end else if (is_bit) begin
            unique case (state)
                ST_IDLE:   nxt = ST_IDLE;
                ST_DRAIN:  nxt = ST_DRAIN;
                ST_DEVNUM: if (cnt == CNT_W'(DEV_W - 1))
                               nxt = (dev_full == '0 || dev_full == my_addr) ? ST_REGNUM : ST_DRAIN;
                ST_REGNUM: if (cnt == CNT_W'(REG_W - 1)) nxt = ST_DIR;
                ST_DIR:    nxt = (bval && bcast) ? ST_DRAIN : ST_DATA;
                ST_DATA:   if (data_last) nxt = ST_PARITY;
                ST_PARITY: nxt = ST_ACK;
                ST_ACK:    nxt = ST_DRAIN;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // frame datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            dev      <= '0;
            reg_addr <= '0;
            shreg    <= '0;
            par      <= 1'b0;
            is_rd    <= 1'b0;
            len16    <= 1'b0;
            my_addr  <= DEV_W'(1);
            rd_stb   <= 1'b0;
            wr_stb   <= 1'b0;
            ack_err  <= 1'b0;
            wr_bcast <= 1'b0;
            wr_data  <= '0;
        end else begin
            rd_stb  <= 1'b0;
            wr_stb  <= 1'b0;
            ack_err <= 1'b0;
            if (is_start) begin
                cnt     <= '0;
                par     <= 1'b0;
                my_addr <= DEV_W'(strap) + DEV_W'(1);
            end else if (is_bit) begin
                cnt <= (nxt != state) ? '0 : cnt + CNT_W'(1);
                if (state inside {ST_DEVNUM, ST_REGNUM, ST_DIR, ST_DATA, ST_PARITY})
                    par <= par ^ bval;
                unique case (state)
                    ST_DEVNUM: dev <= dev_full;
                    ST_REGNUM: reg_addr <= {reg_addr[REG_W-2:0], bval};
                    ST_DIR: begin
                        is_rd <= bval;
                        len16 <= !is_short(reg_addr);
                        if (!bval)
                            shreg <= '0;
                        else if (is_short(reg_addr))
                            shreg <= {rd_val[SHORT_W-1:0], {(DATA_W-SHORT_W){1'b0}}};
                        else
                            shreg <= rd_val;
                    end
                    ST_DATA: shreg <= is_rd ? {shreg[DATA_W-2:0], 1'b0}
                                            : {shreg[DATA_W-2:0], bval};
                    ST_ACK: begin
                        if (bval) begin
                            rd_stb <= is_rd;
                            wr_stb <= !is_rd;
                        end else begin
                            ack_err <= 1'b1;
                        end
                        wr_bcast <= bcast;
                        wr_data  <= len16 ? shreg : DATA_W'(shreg[SHORT_W-1:0]);
                    end
                    default: ;
                endcase
            end
        end
    end

    // slave-owned slot outputs
    always_comb begin
        tx_en  = 1'b0;
        tx_one = 1'b0;
        unique case (state)
            ST_DATA: begin
                tx_en  = is_rd;
                tx_one = is_rd && shreg[DATA_W-1];
            end
            ST_PARITY: begin
                tx_en  = is_rd;
                tx_one = is_rd && par;
            end
            ST_ACK: begin
                tx_en  = !is_rd;
                tx_one = !is_rd && !par;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/sp_slave_engine.sv
module sp_slave_engine
    import sp_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sym_valid,
    input  logic [1:0]          sym_code,
    input  logic [1:0]          strap,
    input  logic [7:0]          status_in,
    input  logic [15:0]         temp_in,
    output logic                tx_en,
    output logic                tx_one,
    output logic                rd_stb,
    output logic                wr_stb,
    output logic [5:0]          reg_addr,
    output logic [15:0]         wr_data,
    output logic                ack_err,
    output logic [15:0]         ctrl_reg,
    output logic [15:0]         tctl_reg,
    output logic [7:0]          rate_reg
);
    logic [DEV_W-1:0]  my_addr;
    logic [DATA_W-1:0] rd_val;
    logic              wr_bcast;

    sp_frame_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sym_valid (sym_valid),
        .sym_code  (sym_code),
        .strap     (strap),
        .rd_val    (rd_val),
        .my_addr   (my_addr),
        .tx_en     (tx_en),
        .tx_one    (tx_one),
        .rd_stb    (rd_stb),
        .wr_stb    (wr_stb),
        .wr_bcast  (wr_bcast),
        .reg_addr  (reg_addr),
        .wr_data   (wr_data),
        .ack_err   (ack_err)
    );

    sp_regfile u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (reg_addr),
        .dev_num   (my_addr),
        .status_in (status_in),
        .temp_in   (temp_in),
        .wr_stb    (wr_stb),
        .wr_bcast  (wr_bcast),
        .wr_data   (wr_data),
        .rd_val    (rd_val),
        .ctrl_reg  (ctrl_reg),
        .tctl_reg  (tctl_reg),
        .rate_reg  (rate_reg)
    );
endmodule

// File: rtl/sp_slave_engine_chk.sv
module sp_slave_engine_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        sym_valid,
    input logic [1:0]  sym_code,
    input logic        tx_en,
    input logic        rd_stb,
    input logic        wr_stb,
    input logic        ack_err,
    input logic [15:0] ctrl_reg
);
    a_r6_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_stb, wr_stb, ack_err}));

    a_r5_commit_after_good_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_stb) |-> $past(sym_valid && sym_code == 2'd1));

    a_r7_read_after_good_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_stb) |-> $past(sym_valid && sym_code == 2'd1));

    a_r6_err_after_zero_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_err) |-> $past(sym_valid && sym_code == 2'd0));

    a_r12_reset_bit_self_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_reg[0] |=> !ctrl_reg[0]);

    a_r9_bus_reset_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && sym_code == 2'd3) |=> !tx_en);
endmodule

bind sp_slave_engine sp_slave_engine_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sym_valid (sym_valid),
    .sym_code  (sym_code),
    .tx_en     (tx_en),
    .rd_stb    (rd_stb),
    .wr_stb    (wr_stb),
    .ack_err   (ack_err),
    .ctrl_reg  (ctrl_reg)
);

// File: tb/tb_sp_slave_engine.sv
module tb_sp_slave_engine;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sym_valid = 1'b0;
    logic [1:0]  sym_code = 2'd0;
    logic [1:0]  strap = 2'b00;
    logic [7:0]  status_in = 8'h00;
    logic [15:0] temp_in = 16'h0000;
    logic        tx_en, tx_one, rd_stb, wr_stb, ack_err;
    logic [5:0]  reg_addr;
    logic [15:0] wr_data, ctrl_reg, tctl_reg;
    logic [7:0]  rate_reg;

    typedef struct {
        int          kind;
        logic [5:0]  addr;
        logic [15:0] data;
    } ev_t;

    ev_t exp_q[$];
    int  checks = 0;
    int  fails = 0;
    bit  done = 0;
    bit  saw_rst_bit = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sp_slave_engine dut (
        .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_code(sym_code),
        .strap(strap), .status_in(status_in), .temp_in(temp_in),
        .tx_en(tx_en), .tx_one(tx_one), .rd_stb(rd_stb), .wr_stb(wr_stb),
        .reg_addr(reg_addr), .wr_data(wr_data), .ack_err(ack_err),
        .ctrl_reg(ctrl_reg), .tctl_reg(tctl_reg), .rate_reg(rate_reg)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int dlen(input logic [5:0] a);
        return (a == 6'h00 || a == 6'h04 || a == 6'h20) ? 8 : 16;
    endfunction

    task automatic send(input logic [1:0] code);
        sym_code  = code;
        sym_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        sym_valid = 1'b0;
    endtask

    task automatic send_bits(input logic [15:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) send(v[i] ? 2'd1 : 2'd0);
    endtask

    task automatic do_read(input logic [2:0] dev, input logic [5:0] ra, input bit ack,
                           input bit responds, output logic [15:0] data,
                           output bit par_ok, output bit saw_tx);
        logic p;
        logic b;
        int   n;
        send(2'd2);
        send_bits({13'b0, dev}, 3);
        send_bits({10'b0, ra}, 6);
        send(2'd1);
        n = dlen(ra);
        data = '0;
        saw_tx = 0;
        p = ^{dev, ra, 1'b1};
        for (int i = 0; i < n; i++) begin
            b = tx_en ? tx_one : 1'b0;
            saw_tx |= tx_en;
            data = {data[14:0], b};
            p ^= b;
            send({1'b0, b});
        end
        b = tx_en ? tx_one : 1'b0;
        saw_tx |= tx_en;
        p ^= b;
        par_ok = (p == 1'b0);
        send({1'b0, b});
        if (responds) exp_q.push_back('{ack ? 0 : 2, ra, 16'h0});
        send(ack ? 2'd1 : 2'd0);
        repeat (2) @(negedge clk);
    endtask

    task automatic rd_check(input logic [2:0] dev, input logic [5:0] ra,
                            input logic [15:0] exp, input string tag);
        logic [15:0] d;
        bit pok, stx;
        do_read(dev, ra, 1'b1, 1'b1, d, pok, stx);
        chk(stx && d == exp, tag, {15'b0, stx, d}, {16'h1, exp});
        chk(pok, {tag, " R3 parity"}, 0, 1);
    endtask

    task automatic do_write(input logic [2:0] dev, input logic [5:0] ra, input logic [15:0] v,
                            input bit bad_par, input bit responds, input string tag);
        logic p;
        int   n;
        bit   exp_ack;
        send(2'd2);
        send_bits({13'b0, dev}, 3);
        send_bits({10'b0, ra}, 6);
        send(2'd0);
        n = dlen(ra);
        send_bits(v, n);
        p = ^{dev, ra, 1'b0};
        for (int i = 0; i < n; i++) p ^= v[i];
        p ^= bad_par;
        send({1'b0, p});
        exp_ack = !bad_par;
        if (responds) begin
            chk(tx_en && tx_one == exp_ack, {tag, " R4 ack slot"}, {tx_en, tx_one}, {1'b1, exp_ack});
            exp_q.push_back('{exp_ack ? 1 : 2, ra, (n == 8) ? {8'h00, v[7:0]} : v});
        end else begin
            chk(!tx_en, {tag, " R1 no drive"}, tx_en, 0);
        end
        send(tx_en ? {1'b0, tx_one} : 2'd0);
        repeat (2) @(negedge clk);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (ctrl_reg[0]) saw_rst_bit = 1;
            if (rd_stb || wr_stb || ack_err) begin
                int kind;
                kind = rd_stb ? 0 : (wr_stb ? 1 : 2);
                if (exp_q.size() == 0) begin
                    chk(0, "R5/R6/R7 unexpected event", kind, 99);
                end else begin
                    ev_t e;
                    e = exp_q.pop_front();
                    chk(kind == e.kind && reg_addr == e.addr, "R5/R6/R7 event kind/addr",
                        {kind[15:0], 10'b0, reg_addr}, {e.kind[15:0], 10'b0, e.addr});
                    if (kind == 1 && e.kind == 1)
                        chk(wr_data == e.data, "R5 write data", wr_data, e.data);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        bit pok, stx;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!tx_en && !rd_stb && !wr_stb && !ack_err, "R11 idle after reset", {tx_en, rd_stb, wr_stb, ack_err}, 0);
        chk(ctrl_reg == 0 && tctl_reg == 0 && rate_reg == 8'h02, "R11 writable resets",
            {ctrl_reg[7:0], tctl_reg[7:0], rate_reg}, 24'h000002);

        // R11 constants, R2 lengths, R1 own address
        rd_check(3'd1, 6'h01, 16'h104C, "R11 reg01");
        rd_check(3'd1, 6'h02, 16'h008D, "R11 reg02");
        rd_check(3'd1, 6'h03, 16'h0001, "R11 reg03");
        rd_check(3'd1, 6'h08, 16'h014A, "R11 reg08");
        rd_check(3'd1, 6'h20, 16'h0002, "R2 R11 reg20 short");
        rd_check(3'd1, 6'h00, 16'h0001, "R1 R2 reg00 address");
        rd_check(3'd1, 6'h15, 16'h0000, "R11 undefined reg");
        status_in = 8'hA5;
        temp_in   = 16'h1F40;
        rd_check(3'd1, 6'h04, 16'h00A5, "R2 reg04 status short");
        rd_check(3'd1, 6'h09, 16'h1F40, "R3 reg09 temperature");

        // R5 committed writes with masks
        do_write(3'd1, 6'h0A, 16'hFFFF, 1'b0, 1'b1, "R5 tctl");
        rd_check(3'd1, 6'h0A, 16'h0003, "R5 tctl readback");
        do_write(3'd1, 6'h20, 16'h00FF, 1'b0, 1'b1, "R5 rate");
        chk(rate_reg == 8'h03, "R5 rate port", rate_reg, 8'h03);

        // R4/R6 bad parity write refused
        do_write(3'd1, 6'h0A, 16'h0000, 1'b1, 1'b1, "R6 bad parity");
        rd_check(3'd1, 6'h0A, 16'h0003, "R6 tctl unchanged");

        // R7 master nack on read: error, no read strobe
        do_read(3'd1, 6'h01, 1'b0, 1'b1, d, pok, stx);
        chk(stx && d == 16'h104C, "R7 nack read data", d, 16'h104C);

        // R13 resample, R1 mismatch
        strap = 2'b10;
        rd_check(3'd3, 6'h00, 16'h0003, "R13 new address");
        do_read(3'd1, 6'h01, 1'b1, 1'b0, d, pok, stx);
        chk(!stx, "R1 old address ignored", stx, 0);
        do_write(3'd5, 6'h0A, 16'h0000, 1'b0, 1'b0, "R1 other address");
        chk(tctl_reg == 16'h0003, "R1 tctl untouched", tctl_reg, 16'h0003);

        // R8 broadcast
        do_read(3'd0, 6'h01, 1'b1, 1'b0, d, pok, stx);
        chk(!stx, "R8 broadcast read ignored", stx, 0);
        do_write(3'd3, 6'h05, 16'h0014, 1'b0, 1'b1, "R5 ctrl");
        chk(ctrl_reg == 16'h0014, "R5 ctrl port", ctrl_reg, 16'h0014);
        do_write(3'd0, 6'h05, 16'h00F2, 1'b0, 1'b1, "R8 bcast ctrl");
        chk(ctrl_reg == 16'h0016, "R8 bcast low bits only", ctrl_reg, 16'h0016);
        do_write(3'd0, 6'h0A, 16'h0000, 1'b0, 1'b1, "R8 bcast tctl");
        chk(tctl_reg == 16'h0003, "R8 bcast other reg untouched", tctl_reg, 16'h0003);

        // R9 restart mid-frame and bus reset
        send(2'd2);
        send_bits(16'h0003, 3);
        send_bits(16'h0002, 4);
        rd_check(3'd3, 6'h03, 16'h0001, "R9 restart mid-frame");
        send(2'd2);
        send_bits(16'h0003, 3);
        send(2'd3);
        send_bits(16'hFFFF, 10);
        chk(!tx_en, "R9 bus reset idle", tx_en, 0);
        rd_check(3'd3, 6'h08, 16'h014A, "R9 after bus reset");

        // R10 extra bits ignored
        do_write(3'd3, 6'h20, 16'h0001, 1'b0, 1'b1, "R10 rate");
        send_bits(16'hFFFF, 5);
        chk(!tx_en, "R10 extra bits no drive", tx_en, 0);
        repeat (2) @(negedge clk);
        rd_check(3'd3, 6'h20, 16'h0001, "R10 rate readback");

        // R12 device reset
        do_write(3'd3, 6'h05, 16'h0015, 1'b0, 1'b1, "R12 reset write");
        repeat (3) @(negedge clk);
        chk(saw_rst_bit, "R12 reset bit seen", saw_rst_bit, 1);
        chk(ctrl_reg == 0 && tctl_reg == 0 && rate_reg == 8'h02, "R12 defaults restored",
            {ctrl_reg[7:0], tctl_reg[7:0], rate_reg}, 24'h000002);
        rd_check(3'd3, 6'h05, 16'h0000, "R12 ctrl readback");

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R5/R6/R7 scoreboard drained", exp_q.size(), 0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule